// File: doc/BRIEF.md
# Piecewise-Linear Gamma Curve Engine

This block applies a transfer curve to a stream of three-channel pixels (red, green, blue), as used for de-gamma on the way into a colour pipeline or re-gamma on the way out. Each channel is mapped through a piecewise-linear curve held in one of two LUT RAMs. Each LUT entry stores, per channel, a base level and a signed slope (delta). The input range is cut into regions by the position of the input's leading one. Each region is split into a programmable power-of-two number of segments, and each region has its own starting LUT address. Inside a segment, the output is the base plus the delta scaled by the fractional position, rounded and clamped.

Software keeps one RAM live and fills the other through an index/data write port. It sets the starting index, then streams six words per entry; a three-bit channel mask decides which channel RAMs take the data. When the idle RAM is loaded, software changes the mode to make that RAM live. The write port refuses data aimed at the live RAM, so the datapath never reads a RAM that is being changed. Two fixed built-in curves and a pass-through are also selectable. A status code reports which RAM is live.

Pixels enter and leave on valid/ready streams. A pixel is taken when `in_valid` and `in_ready` are both high, and its result is presented one cycle later. The result stays on `out_pix` with `out_valid` high until `out_ready` is seen high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. The write port is also valid/ready: a word is taken when `wr_valid` and `wr_ready` are both high.

Top module: `pwl_gamma_engine`

## Requirements
- R1: After reset, `out_valid` is 0, `status` is 0, `in_ready` and `wr_ready` are 1, and the write position is entry 0, word 0.
- R2: A one-cycle `wr_idx_load` sets the write entry to `wr_idx` and restarts the word count. Each entry then takes six accepted words in the order red base, green base, blue base, red delta, green delta, blue delta. After the sixth word the entry index advances by one.
- R3: `wr_mask` bit 0 enables red, bit 1 green and bit 2 blue. A word for a masked-off channel leaves that RAM unchanged, but the six-word sequence still advances.
- R4: `wr_sel` 0 targets RAM A and 1 targets RAM B. `wr_ready` is 0 while `wr_idx_load` is high, and while the targeted RAM is the live one (mode 3 with `wr_sel` 0, or mode 4 with `wr_sel` 1).
- R5: `mode` 0 passes the input through. Mode 1 gives the square-law curve x*x >> (2*IN_W-OUT_W). Mode 2 gives the cube-law curve x*x*x >> (3*IN_W-OUT_W). Mode 3 uses RAM A and mode 4 uses RAM B. Modes 5 to 7 act as pass-through. A mode change takes effect one cycle after it is applied.
- R6: `status` is 9 while RAM A is live, 10 while RAM B is live, and 0 otherwise.
- R7: For a nonzero input x, the region p is the bit index of its leading one. The segment log2 count is s = min(region_seg[p], p). The segment number is the s bits directly below the leading one. The LUT address is (region_ofs[p] + segment) mod DEPTH.
- R8: The fraction f is made of the remaining p-s low bits, left-aligned to FRAC_W = IN_W-1 bits. The output is base + floor((delta*f + 2^(FRAC_W-1)) / 2^FRAC_W), where the 12-bit delta is two's complement.
- R9: The result of R8 is clamped to the range 0 to 2^OUT_W-1.
- R10: In RAM modes, an input of 0 gives that channel's `start_val`. An input whose region p exceeds `last_region` gives that channel's `end_val`.
- R11: `in_ready` = !`out_valid` || `out_ready`. An accepted pixel's result appears with `out_valid` on the next cycle. While `out_valid` is 1 and `out_ready` is 0, `out_pix` holds and no new pixel is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Curve selection (R5) |
| status | output | 4 | Live RAM code: 9 A, 10 B, 0 none |
| wr_idx_load | input | 1 | Load the write entry index |
| wr_idx | input | ADDR_W | Entry index to load |
| wr_sel | input | 1 | Target RAM: 0 A, 1 B |
| wr_mask | input | 3 | Channel write enables (bit0 red) |
| wr_valid | input | 1 | Write word valid |
| wr_ready | output | 1 | Write word may be accepted |
| wr_data | input | OUT_W | Write word (base or signed delta) |
| region_ofs | input | IN_W*ADDR_W | Per-region LUT start address |
| region_seg | input | IN_W*SEG_W | Per-region log2 segment count |
| last_region | input | RGN_W | Highest region inside the curve |
| start_val | input | 3*OUT_W | Per-channel output for input 0 |
| end_val | input | 3*OUT_W | Per-channel output above last region |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel may be accepted |
| in_pix | input | 3*IN_W | Input pixel, red in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_pix | output | 3*OUT_W | Output pixel, red in the low bits |

## Verification
The embedded properties check on every cycle that: the output stays frozen under back-pressure; an accepted pixel always yields a valid output; the status code follows the previous cycle's mode; no word is ever written into the live RAM; and the entry index steps exactly once per six words. Only the bench scenarios can show that the numbers are right. These scenarios cover region and segment address decoding with wraparound, the rounded interpolation and its clamping at both ends, channel masking, the six-word ordering, the start and end values, and the built-in curves. They compare each output against a curve model built from the requirements.

// File: rtl/pwl_gamma_pkg.sv
package pwl_gamma_pkg;
  localparam int NUM_CH          = 3;
  localparam int WORDS_PER_ENTRY = 6;
  localparam logic [2:0] MODE_PASS  = 3'd0;
  localparam logic [2:0] MODE_SQR   = 3'd1;
  localparam logic [2:0] MODE_CUBE  = 3'd2;
  localparam logic [2:0] MODE_RAM_A = 3'd3;
  localparam logic [2:0] MODE_RAM_B = 3'd4;
  localparam logic [3:0] STAT_NONE  = 4'd0;
  localparam logic [3:0] STAT_A     = 4'd9;
  localparam logic [3:0] STAT_B     = 4'd10;
endpackage

// File: rtl/pwl_lut_bank.sv
module pwl_lut_bank #(
  parameter int OUT_W  = 12,
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_load,
  input  logic [ADDR_W-1:0]    idx_value,
  input  logic                 wr_fire,
  input  logic [OUT_W-1:0]     wr_data,
  input  logic [2:0]           wr_mask,
  input  logic                 wr_sel,
  input  logic                 live_use,
  input  logic                 live_sel,
  input  logic [3*ADDR_W-1:0]  rd_addr,
  output logic [3*OUT_W-1:0]   rd_base,
  output logic [3*OUT_W-1:0]   rd_delta
);
  import pwl_gamma_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [OUT_W-1:0] base_m  [2][NUM_CH][DEPTH];
  logic [OUT_W-1:0] delta_m [2][NUM_CH][DEPTH];
  logic [ADDR_W-1:0] idx_q;
  logic [2:0]        cnt_q;
  logic [1:0]        ch;
  logic              is_delta;

  assign is_delta = (cnt_q >= 3'd3);
  assign ch       = is_delta ? 2'(cnt_q - 3'd3) : cnt_q[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (idx_load) begin
      idx_q <= idx_value;
      cnt_q <= '0;
    end else if (wr_fire) begin
      if (cnt_q == 3'(WORDS_PER_ENTRY - 1)) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_fire && !idx_load && wr_mask[ch]) begin
      if (is_delta) delta_m[wr_sel][ch][idx_q] <= wr_data;
      else          base_m[wr_sel][ch][idx_q]  <= wr_data;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_rd
    assign rd_base[c*OUT_W +: OUT_W]  = base_m[live_sel][c][rd_addr[c*ADDR_W +: ADDR_W]];
    assign rd_delta[c*OUT_W +: OUT_W] = delta_m[live_sel][c][rd_addr[c*ADDR_W +: ADDR_W]];
  end

  assert_word_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < 3'(WORDS_PER_ENTRY));
  assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !idx_load && cnt_q == 3'(WORDS_PER_ENTRY - 1)) |=> idx_q == $past(idx_q) + 1'b1);
  assert_no_live_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> !(live_use && (wr_sel == live_sel)));
endmodule

// File: rtl/pwl_seg_addr.sv
module pwl_seg_addr #(
  parameter int IN_W   = 12,
  parameter int ADDR_W = 5,
  parameter int SEG_W  = 3,
  parameter int RGN_W  = 4,
  parameter int FRAC_W = IN_W - 1
) (
  input  logic [IN_W-1:0]        x,
  input  logic [IN_W*ADDR_W-1:0] region_ofs,
  input  logic [IN_W*SEG_W-1:0]  region_seg,
  input  logic [RGN_W-1:0]       last_region,
  output logic [ADDR_W-1:0]      addr,
  output logic [FRAC_W-1:0]      frac,
  output logic                   below,
  output logic                   above
);
  int p, s, sh;
  logic [IN_W-1:0] m, seg_idx, rem, fr_full;

  always_comb begin
    p = 0;
    for (int i = 0; i < IN_W; i++) if (x[i]) p = i;
    s  = (int'(region_seg[p*SEG_W +: SEG_W]) > p) ? p : int'(region_seg[p*SEG_W +: SEG_W]);
    sh = p - s;
    m       = x & ((IN_W'(1) << p) - IN_W'(1));
    seg_idx = m >> sh;
    rem     = m & ((IN_W'(1) << sh) - IN_W'(1));
    fr_full = rem << (FRAC_W - sh);
    frac    = fr_full[FRAC_W-1:0];
    addr    = region_ofs[p*ADDR_W +: ADDR_W] + seg_idx[ADDR_W-1:0];
    below   = (x == '0);
    above   = (p > int'(last_region));
  end
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
  parameter int OUT_W  = 12,
  parameter int FRAC_W = 11
) (
  input  logic [OUT_W-1:0]  base,
  input  logic [OUT_W-1:0]  delta,
  input  logic [FRAC_W-1:0] frac,
  output logic [OUT_W-1:0]  y
);
  localparam int PW = OUT_W + FRAC_W + 2;
  localparam int SW = OUT_W + 2;
  logic signed [PW-1:0] d_ext, f_ext, prod, rnd;
  logic signed [SW-1:0] sum;

  always_comb begin
    d_ext = {{(PW-OUT_W){delta[OUT_W-1]}}, delta};
    f_ext = {{(PW-FRAC_W){1'b0}}, frac};
    prod  = d_ext * f_ext;
    rnd   = (prod + (PW'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
    sum   = $signed({2'b00, base}) + rnd[SW-1:0];
    if (sum < 0)                                 y = '0;
    else if (sum > $signed({2'b00, {OUT_W{1'b1}}})) y = '1;
    else                                         y = sum[OUT_W-1:0];
  end
endmodule

// File: rtl/pwl_gamma_engine.sv
module pwl_gamma_engine #(
  parameter int IN_W   = 12,
  parameter int OUT_W  = 12,
  parameter int ADDR_W = 5,
  parameter int SEG_W  = 3,
  parameter int RGN_W  = $clog2(IN_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             mode,
  output logic [3:0]             status,
  input  logic                   wr_idx_load,
  input  logic [ADDR_W-1:0]      wr_idx,
  input  logic                   wr_sel,
  input  logic [2:0]             wr_mask,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [OUT_W-1:0]       wr_data,
  input  logic [IN_W*ADDR_W-1:0] region_ofs,
  input  logic [IN_W*SEG_W-1:0]  region_seg,
  input  logic [RGN_W-1:0]       last_region,
  input  logic [3*OUT_W-1:0]     start_val,
  input  logic [3*OUT_W-1:0]     end_val,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [3*IN_W-1:0]      in_pix,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [3*OUT_W-1:0]     out_pix
);
  import pwl_gamma_pkg::*;
  localparam int FRAC_W = IN_W - 1;

  logic [2:0] mode_q;
  logic       live_use, live_sel, wr_fire;
  logic [3*ADDR_W-1:0] rd_addr;
  logic [3*OUT_W-1:0]  rd_base, rd_delta, res;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_PASS;
    else        mode_q <= mode;
  end

  assign live_use = (mode_q == MODE_RAM_A) || (mode_q == MODE_RAM_B);
  assign live_sel = (mode_q == MODE_RAM_B);
  assign status   = (mode_q == MODE_RAM_A) ? STAT_A :
                    (mode_q == MODE_RAM_B) ? STAT_B : STAT_NONE;
  assign wr_ready = !wr_idx_load && !(live_use && (wr_sel == live_sel));
  assign wr_fire  = wr_valid && wr_ready;
  assign in_ready = !out_valid || out_ready;

  pwl_lut_bank #(.OUT_W(OUT_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .idx_load(wr_idx_load), .idx_value(wr_idx),
    .wr_fire(wr_fire), .wr_data(wr_data), .wr_mask(wr_mask), .wr_sel(wr_sel),
    .live_use(live_use), .live_sel(live_sel), .rd_addr(rd_addr),
    .rd_base(rd_base), .rd_delta(rd_delta));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [IN_W-1:0]   xc;
    logic [2*IN_W-1:0] sq;
    logic [3*IN_W-1:0] cube;
    logic [FRAC_W-1:0] frac;
    logic              below, above;
    logic [OUT_W-1:0]  lin, pass, sq_o, cube_o;

    assign xc   = in_pix[c*IN_W +: IN_W];
    assign sq   = xc * xc;
    assign cube = sq * xc;
    assign sq_o   = OUT_W'(sq >> (2*IN_W - OUT_W));
    assign cube_o = OUT_W'(cube >> (3*IN_W - OUT_W));

    if (OUT_W >= IN_W) begin : g_up
      assign pass = OUT_W'(xc) << (OUT_W - IN_W);
    end else begin : g_dn
      assign pass = OUT_W'(xc >> (IN_W - OUT_W));
    end

    pwl_seg_addr #(.IN_W(IN_W), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .RGN_W(RGN_W),
                   .FRAC_W(FRAC_W)) u_addr (
      .x(xc), .region_ofs(region_ofs), .region_seg(region_seg),
      .last_region(last_region), .addr(rd_addr[c*ADDR_W +: ADDR_W]),
      .frac(frac), .below(below), .above(above));

    pwl_interp #(.OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_interp (
      .base(rd_base[c*OUT_W +: OUT_W]), .delta(rd_delta[c*OUT_W +: OUT_W]),
      .frac(frac), .y(lin));

    always_comb begin
      case (mode_q)
        MODE_SQR:  res[c*OUT_W +: OUT_W] = sq_o;
        MODE_CUBE: res[c*OUT_W +: OUT_W] = cube_o;
        MODE_RAM_A, MODE_RAM_B:
          res[c*OUT_W +: OUT_W] = below ? start_val[c*OUT_W +: OUT_W] :
                                  above ? end_val[c*OUT_W +: OUT_W] : lin;
        default:   res[c*OUT_W +: OUT_W] = pass;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_pix   <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));
  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  assert_status_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_RAM_A) |-> status == STAT_A);
  assert_status_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode) == MODE_RAM_B) |-> status == STAT_B);
endmodule

// File: tb/pwl_gamma_engine_tb.sv
module pwl_gamma_engine_tb;
  localparam int IN_W = 12, OUT_W = 12, ADDR_W = 5, SEG_W = 3, RGN_W = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] mode = 0;
  logic [3:0] status;
  logic wr_idx_load = 0, wr_sel = 0, wr_valid = 0, wr_ready;
  logic [ADDR_W-1:0] wr_idx = 0;
  logic [2:0] wr_mask = 3'b111;
  logic [OUT_W-1:0] wr_data = 0;
  logic [IN_W*ADDR_W-1:0] region_ofs;
  logic [IN_W*SEG_W-1:0] region_seg;
  logic [RGN_W-1:0] last_region = 4'd11;
  logic [3*OUT_W-1:0] start_val = {12'd30, 12'd20, 12'd10};
  logic [3*OUT_W-1:0] end_val   = {12'd2000, 12'd3000, 12'd4000};
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [3*IN_W-1:0] in_pix = 0;
  logic [3*OUT_W-1:0] out_pix;

  int n_chk = 0, n_bad = 0;
  int m_base [2][3][32];
  int m_delta[2][3][32];
  int b_idx = 0, b_cnt = 0, cur_mode = 0, last_r = 11;
  int lo[3];

  pwl_gamma_engine u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    for (int p = 0; p < IN_W; p++) begin
      region_ofs[p*ADDR_W +: ADDR_W] = ADDR_W'((3*p) % 32);
      region_seg[p*SEG_W +: SEG_W]   = 3'd2;
    end
    for (int b = 0; b < 2; b++) for (int c = 0; c < 3; c++) for (int e = 0; e < 32; e++) begin
      m_base[b][c][e] = 0; m_delta[b][c][e] = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ch(int c, int x, int md);
    int p, s, sh, m, sg, rem, fr, a, d, v, bk;
    longint cu;
    if (md == 1) return (x * x) >> 12;
    if (md == 2) begin cu = longint'(x) * x * x; return int'(cu >> 24); end
    if (md != 3 && md != 4) return x;
    bk = md - 3;
    if (x == 0) return (c == 0) ? 10 : (c == 1) ? 20 : 30;
    p = 0;
    for (int i = 0; i < 12; i++) if ((x >> i) & 1) p = i;
    if (p > last_r) return (c == 0) ? 4000 : (c == 1) ? 3000 : 2000;
    s = (p < 2) ? p : 2;
    sh = p - s;
    m = x & ((1 << p) - 1);
    sg = m >> sh;
    rem = m & ((1 << sh) - 1);
    fr = rem << (11 - sh);
    a = ((3 * p) + sg) % 32;
    d = m_delta[bk][c][a];
    if (d >= 2048) d -= 4096;
    v = m_base[bk][c][a] + ((d * fr + 1024) >>> 11);
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic put_word(int v, string req);
    int c;
    wr_valid = 1; wr_data = OUT_W'(v);
    #1 chk(req, int'(wr_ready), 1);
    c = (b_cnt < 3) ? b_cnt : b_cnt - 3;
    if (wr_mask[c]) begin
      if (b_cnt < 3) m_base[wr_sel][c][b_idx] = v & 12'hFFF;
      else           m_delta[wr_sel][c][b_idx] = v & 12'hFFF;
    end
    if (b_cnt == 5) begin b_cnt = 0; b_idx = (b_idx + 1) % 32; end
    else b_cnt++;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic set_index(int i);
    wr_idx_load = 1; wr_idx = ADDR_W'(i);
    @(negedge clk);
    wr_idx_load = 0; b_idx = i; b_cnt = 0;
  endtask

  task automatic set_mode(int md);
    mode = 3'(md); cur_mode = md;
    @(negedge clk);
  endtask

  task automatic load_bank(int sel, int n);
    wr_sel = sel[0]; wr_mask = 3'b111;
    set_index(0);
    for (int e = 0; e < n; e++) begin
      for (int c = 0; c < 3; c++) put_word((e*97 + c*31 + sel*500) % 4096, "R2");
      for (int c = 0; c < 3; c++) put_word(((e*53 + c*17) % 512 - 256) & 12'hFFF, "R2");
    end
  endtask

  task automatic send_pix(int r, int g, int b, string req);
    int xs[3];
    xs[0] = r; xs[1] = g; xs[2] = b;
    in_pix = {IN_W'(b), IN_W'(g), IN_W'(r)}; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    for (int c = 0; c < 3; c++) begin
      lo[c] = int'(out_pix[c*OUT_W +: OUT_W]);
      chk(req, lo[c], exp_ch(c, xs[c], cur_mode));
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_default_index;
    wr_sel = 1; wr_mask = 3'b111;
    put_word(111, "R1"); put_word(222, "R1"); put_word(333, "R1");
    put_word(0, "R1");   put_word(0, "R1");   put_word(0, "R1");
    set_mode(4);
    send_pix(1, 1, 1, "R1 entry0");
    chk("R1 red entry0", lo[0], 111);
  endtask

  task automatic t_load_a;
    set_mode(0);
    load_bank(0, 32);
    set_mode(3);
    chk("R6 status A", int'(status), 9);
    send_pix(12'h001, 12'h003, 12'h0A5, "R7");
    send_pix(12'h7FF, 12'h456, 12'hFFF, "R8");
    send_pix(12'h9C3, 12'h02F, 12'h5A5, "R8");
  endtask

  task automatic t_ping_pong;
    wr_sel = 0; wr_valid = 1;
    #1 chk("R4 live A blocked", int'(wr_ready), 0);
    wr_sel = 1; wr_idx_load = 1;
    #1 chk("R4 idx_load blocks", int'(wr_ready), 0);
    wr_valid = 0;
    @(negedge clk);
    wr_idx_load = 0;
    load_bank(1, 32);
    set_mode(4);
    chk("R6 status B", int'(status), 10);
    wr_sel = 1;
    #1 chk("R4 live B blocked", int'(wr_ready), 0);
    wr_sel = 0;
    #1 chk("R4 idle A open", int'(wr_ready), 1);
    send_pix(12'h123, 12'hABC, 12'h801, "R7");
    send_pix(12'h3FF, 12'h040, 12'hC00, "R8");
  endtask

  task automatic t_mask;
    set_mode(3);
    wr_sel = 1; wr_mask = 3'b010;
    set_index(4);
    for (int k = 0; k < 6; k++) put_word(12'hABC, "R3");
    wr_mask = 3'b111;
    set_mode(4);
    send_pix(12'hFFF, 12'hFFF, 12'hFFF, "R3");
    chk("R3 red untouched", lo[0], (97*4 + 500) % 4096 + 0 + exp_ch(0, 12'hFFF, 4) - ((97*4 + 500) % 4096));
  endtask

  task automatic t_sat;
    set_mode(3);
    wr_sel = 1; wr_mask = 3'b111;
    set_index(4);
    put_word(4000, "R9"); put_word(10, "R9"); put_word(100, "R9");
    put_word(2000, "R9"); put_word(12'h830, "R9"); put_word(0, "R9");
    set_mode(4);
    send_pix(12'hFFF, 12'hFFF, 12'hFFF, "R9");
    chk("R9 clamp high", lo[0], 4095);
    chk("R9 clamp low", lo[1], 0);
    chk("R9 zero delta", lo[2], 100);
  endtask

  task automatic t_range;
    last_region = 4'd8; last_r = 8;
    send_pix(0, 12'h200, 12'h1FF, "R10");
    chk("R10 start red", lo[0], 10);
    chk("R10 end green", lo[1], 3000);
    send_pix(12'hFFF, 0, 12'h100, "R10");
    last_region = 4'd11; last_r = 11;
  endtask

  task automatic t_builtin;
    set_mode(1);
    chk("R6 status none", int'(status), 0);
    send_pix(12'hFFF, 12'h800, 12'h123, "R5 square");
    set_mode(2);
    send_pix(12'hFFF, 12'h800, 12'hA00, "R5 cube");
    set_mode(0);
    send_pix(12'h456, 12'h000, 12'hFFF, "R5 pass");
    set_mode(6);
    send_pix(12'h789, 12'h001, 12'hBEE, "R5 mode6");
  endtask

  task automatic t_stall;
    int held;
    set_mode(3);
    out_ready = 0;
    in_pix = {12'h300, 12'h200, 12'h100}; in_valid = 1;
    @(negedge clk);
    in_pix = {12'h0F0, 12'h0E0, 12'h0D0};
    chk("R11 valid", int'(out_valid), 1);
    chk("R11 in_ready low", int'(in_ready), 0);
    held = int'(out_pix[OUT_W-1:0]);
    chk("R11 first", held, exp_ch(0, 12'h100, 3));
    repeat (3) @(negedge clk);
    chk("R11 still valid", int'(out_valid), 1);
    chk("R11 held", int'(out_pix[OUT_W-1:0]), held);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R11 second", int'(out_pix[OUT_W-1:0]), exp_ch(0, 12'h0D0, 3));
    chk("R11 second blue", int'(out_pix[2*OUT_W +: OUT_W]), exp_ch(2, 12'h0F0, 3));
    @(negedge clk);
    chk("R11 drained", int'(out_valid), 0);
  endtask

  initial begin
    t_reset;
    t_default_index;
    t_load_a;
    t_ping_pong;
    t_mask;
    t_sat;
    t_range;
    t_builtin;
    t_stall;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule